// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is a single transmit DMA channel driven by a ring of descriptors in shared memory. Software builds the descriptors and then starts the channel with a command. From then on the channel walks the ring by following next pointers. For each descriptor it reads that descriptor's buffer one word at a time over a simple word-addressed memory port. It sends the bytes out on a valid/ready byte stream, marking the first and last byte of the frame when the descriptor asks for it. When a descriptor is finished, the channel writes a completion flag back into the descriptor's status word.

Flow control works through ownership bits. A descriptor whose hold bit is set is not transmitted: the channel parks on it and re-reads its control word after a programmable polling delay. Software clears the hold bit of the slot behind the one it has just filled, so the hardware can never overtake the producer. A resume command skips the remaining wait. An off command stops the channel at once. A next pointer that is not on a 16-byte boundary stops the channel and raises an error flag.

Top module: `txdma_ring_chan`

## Requirements
- R1: After reset the outputs chan_busy, chan_held, chan_err, irq_flag, tx_valid and mem_req are all 0. The polling time resets to 7.
- R2: A descriptor is four 32-bit words at a 16-byte-aligned byte address D, read at word addresses D/4+0 to D/4+3. Word 0 is control: bit 31 hold, bit 30 end-of-frame, bit 29 start-of-frame, bit 28 completion-flag enable, bit 27 end-of-frame-flag enable, bits 21:0 byte count. Word 1 is the next descriptor byte address. Word 2 is the buffer byte address. Word 3 is the status word.
- R3: The bytes of a frame leave in ascending byte address, starting at the buffer address, which may have any alignment. The byte at byte address a is bits 8*(a mod 4)+7 to 8*(a mod 4) of memory word a/4. While tx_ready is low, tx_valid, tx_data and the markers hold steady.
- R4: tx_sop is high only on the first byte of a frame whose control bit 29 is set. tx_eop is high only on the last byte of a frame whose control bit 30 is set.
- R5: After the last byte is accepted, the channel writes 0x80000000 to word 3 of the descriptor (bit 31 is the completion flag C). It then continues with the descriptor at the next pointer, so a ring closes on itself.
- R6: A descriptor with control bit 31 set sends no bytes and gets no write-back, and chan_held is 1. Its control word is read again every 16*P+3 cycles, where P is the polling time. P=0 gives a re-read every 3 cycles.
- R7: A descriptor with byte count 0 gets its completion write and sends no byte.
- R8: If a next pointer or the first-descriptor address has any of bits 3:0 set, chan_err goes to 1 and chan_busy goes to 0. No further memory access takes place until an init command.
- R9: Command writes use register select 1 with code wdata[1:0]: 0 off, 1 init, 2 resume. Init starts at the first-descriptor address. Off makes chan_busy 0 on the next cycle, after which no memory access and no byte occurs. Resume, when idle or held, re-reads the current descriptor immediately and cuts any polling wait short.
- R10: irq_flag is set when a descriptor completes with control bit 28 set, or with bits 27 and 30 both set. It is cleared by any command write.
- R11: Register select 0 holds the first-descriptor byte address and select 2 holds the polling time. A write to select 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_sop | output | 1 | First byte of frame |
| tx_eop | output | 1 | Last byte of frame |
| chan_busy | output | 1 | Channel running |
| chan_held | output | 1 | Parked on a held descriptor |
| chan_err | output | 1 | Alignment error, channel stopped |
| irq_flag | output | 1 | Completion event flag |

## Verification
If the byte pointer or the lane select is wrong, it shows within the first few bytes of a frame as a wrong or reordered byte. Unaligned buffers make an off-by-one in lane order visible on the first word. A wrong remaining count shows at the end of the frame as a missing or extra byte, a misplaced end marker, or a completion write that is early or never comes. A wrong polling counter shifts the spacing of repeated control-word reads at the memory port by a whole number of cycles during the very next wait. A wrong command priority or next-pointer latch shows as traffic after an off command, or as the wrong descriptor being fetched after a completion.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  localparam int WORD_W       = 32;
  localparam int CNT_W        = 22;
  localparam int POLL_SHIFT   = 4;
  localparam int POLL_DEFAULT = 7;

  localparam logic [WORD_W-1:0] DONE_WORD = 32'h8000_0000;

  localparam logic [1:0] SEL_FIRST = 2'd0;
  localparam logic [1:0] SEL_CMD   = 2'd1;
  localparam logic [1:0] SEL_POLL  = 2'd2;

  typedef enum logic [1:0] {
    CMD_OFF    = 2'd0,
    CMD_INIT   = 2'd1,
    CMD_RESUME = 2'd2,
    CMD_NONE   = 2'd3
  } cmd_code_e;

  typedef struct packed {
    logic             hold;
    logic             eof;
    logic             sof;
    logic             cpl_int;
    logic             eof_int;
    logic [4:0]       rsvd;
    logic [CNT_W-1:0] count;
  } ctl_word_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RCTL,
    ST_WCTL,
    ST_RNXT,
    ST_RBUF,
    ST_WBUF,
    ST_RDAT,
    ST_LDAT,
    ST_SEND,
    ST_DONE,
    ST_POLL
  } chan_state_e;

endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
  import txdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] first_addr,
  output logic [POLL_W-1:0] poll_time,
  output logic              cmd_off,
  output logic              cmd_init,
  output logic              cmd_resume,
  output logic              cmd_any
);

  localparam logic [POLL_W-1:0] POLL_RST = POLL_W'(POLL_DEFAULT);

  logic              first_en;
  logic              poll_en;
  logic              cmd_wr;
  cmd_code_e         code;
  logic [ADDR_W-1:0] first_nxt;
  logic [POLL_W-1:0] poll_nxt;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  assign first_en = cfg_we && (cfg_sel == SEL_FIRST);
  assign poll_en  = cfg_we && (cfg_sel == SEL_POLL);
  assign cmd_wr   = cfg_we && (cfg_sel == SEL_CMD);
  assign code     = cmd_code_e'(cfg_wdata[1:0]);

  assign cmd_any    = cmd_wr && (code != CMD_NONE);
  assign cmd_off    = cmd_wr && (code == CMD_OFF);
  assign cmd_init   = cmd_wr && (code == CMD_INIT);
  assign cmd_resume = cmd_wr && (code == CMD_RESUME);

  always_comb begin
    first_nxt = first_addr;
    poll_nxt  = poll_time;
    if (first_en) first_nxt = cfg_wdata[ADDR_W-1:0];
    if (poll_en)  poll_nxt  = cfg_wdata[POLL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_addr <= '0;
      poll_time  <= POLL_RST;
    end else begin
      if (first_en) first_addr <= first_nxt;
      if (poll_en)  poll_time  <= poll_nxt;
    end
  end

endmodule

// File: rtl/txdma_poll_timer.sv
module txdma_poll_timer
  import txdma_pkg::*;
#(
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [POLL_W-1:0] poll_time,
  output logic              expired
);

  localparam int TMR_W = POLL_W + POLL_SHIFT;

  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_n;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;

  always_comb begin
    if (load) cnt_n = {poll_time, {POLL_SHIFT{1'b0}}};
    else      cnt_n = cnt_q - TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

endmodule

// File: rtl/txdma_byte_lane.sv
module txdma_byte_lane
  import txdma_pkg::*;
#(
  parameter int LANES  = WORD_W / 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [LANE_W-1:0] lane,
  output logic [7:0]        byte_out
);

  logic [WORD_W-1:0] word_q;
  logic [7:0]        lane_bytes [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_in;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = word_q[8*g +: 8];
  end

  assign byte_out = lane_bytes[lane];

endmodule

// File: rtl/txdma_ring_chan.sv
module txdma_ring_chan
  import txdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              chan_busy,
  output logic              chan_held,
  output logic              chan_err,
  output logic              irq_flag
);

  localparam int LANE_W = $clog2(WORD_W / 8);
  localparam int DBASE_W = ADDR_W - 4;

  logic rst_s1, rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sn, rst_s1} <= 2'b00;
    else        {rst_sn, rst_s1} <= {rst_s1, 1'b1};
  end

  logic [ADDR_W-1:0] first_addr;
  logic [POLL_W-1:0] poll_time;
  logic              cmd_off, cmd_init, cmd_resume, cmd_any;

  txdma_regs #(.ADDR_W(ADDR_W), .POLL_W(POLL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sn),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .first_addr (first_addr),
    .poll_time  (poll_time),
    .cmd_off    (cmd_off),
    .cmd_init   (cmd_init),
    .cmd_resume (cmd_resume),
    .cmd_any    (cmd_any)
  );

  logic tmr_load, tmr_expired;

  txdma_poll_timer #(.POLL_W(POLL_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sn),
    .load      (tmr_load),
    .poll_time (poll_time),
    .expired   (tmr_expired)
  );

  chan_state_e       state_q, state_n;
  logic [ADDR_W-1:0] cur_q, cur_n;
  logic [ADDR_W-1:0] nxt_q, nxt_n;
  logic [ADDR_W-1:0] buf_q, buf_n;
  logic [CNT_W-1:0]  rem_q, rem_n;
  ctl_word_t         ctl_q, ctl_n;
  logic              first_q, first_n;
  logic              err_q, err_n;
  logic              irq_q, irq_n;
  logic              lane_load;
  logic [7:0]        lane_byte;
  logic [DBASE_W-1:0] dbase;
  logic              unused_bits;

  assign dbase       = cur_q[ADDR_W-1:4];
  assign unused_bits = ^{ctl_q.rsvd, cur_q[3:0]};

  txdma_byte_lane u_lane (
    .clk      (clk),
    .rst_n    (rst_sn),
    .load     (lane_load),
    .word_in  (mem_rdata),
    .lane     (buf_q[LANE_W-1:0]),
    .byte_out (lane_byte)
  );

  always_comb begin
    state_n   = state_q;
    cur_n     = cur_q;
    nxt_n     = nxt_q;
    buf_n     = buf_q;
    rem_n     = rem_q;
    ctl_n     = ctl_q;
    first_n   = first_q;
    err_n     = err_q;
    irq_n     = irq_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    tmr_load  = 1'b0;
    lane_load = 1'b0;
    tx_valid  = 1'b0;

    case (state_q)
      ST_IDLE: ;
      ST_RCTL: begin
        mem_req  = 1'b1;
        mem_addr = {dbase, 2'd0};
        state_n  = ST_WCTL;
      end
      ST_WCTL: begin
        ctl_n = ctl_word_t'(mem_rdata);
        if (mem_rdata[31]) begin
          tmr_load = 1'b1;
          state_n  = ST_POLL;
        end else begin
          state_n  = ST_RNXT;
        end
      end
      ST_RNXT: begin
        mem_req  = 1'b1;
        mem_addr = {dbase, 2'd1};
        state_n  = ST_RBUF;
      end
      ST_RBUF: begin
        nxt_n    = mem_rdata[ADDR_W-1:0];
        mem_req  = 1'b1;
        mem_addr = {dbase, 2'd2};
        state_n  = ST_WBUF;
      end
      ST_WBUF: begin
        buf_n   = mem_rdata[ADDR_W-1:0];
        rem_n   = ctl_q.count;
        first_n = 1'b1;
        state_n = (ctl_q.count == '0) ? ST_DONE : ST_RDAT;
      end
      ST_RDAT: begin
        mem_req  = 1'b1;
        mem_addr = buf_q[ADDR_W-1:2];
        state_n  = ST_LDAT;
      end
      ST_LDAT: begin
        lane_load = 1'b1;
        state_n   = ST_SEND;
      end
      ST_SEND: begin
        tx_valid = 1'b1;
        if (tx_ready) begin
          buf_n   = buf_q + ADDR_W'(1);
          rem_n   = rem_q - CNT_W'(1);
          first_n = 1'b0;
          if (rem_q == CNT_W'(1))        state_n = ST_DONE;
          else if (&buf_q[LANE_W-1:0])   state_n = ST_RDAT;
        end
      end
      ST_DONE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {dbase, 2'd3};
        mem_wdata = DONE_WORD;
        if (ctl_q.cpl_int || (ctl_q.eof_int && ctl_q.eof)) irq_n = 1'b1;
        if (nxt_q[3:0] != 4'd0) begin
          err_n   = 1'b1;
          state_n = ST_IDLE;
        end else begin
          cur_n   = nxt_q;
          state_n = ST_RCTL;
        end
      end
      ST_POLL: begin
        if (tmr_expired) state_n = ST_RCTL;
      end
      default: state_n = ST_IDLE;
    endcase

    if (cmd_any) irq_n = 1'b0;

    if (cmd_off) begin
      state_n = ST_IDLE;
    end else if (cmd_init) begin
      cur_n = first_addr;
      if (first_addr[3:0] != 4'd0) begin
        err_n   = 1'b1;
        state_n = ST_IDLE;
      end else begin
        err_n   = 1'b0;
        state_n = ST_RCTL;
      end
    end else if (cmd_resume && !err_q &&
                 (state_q == ST_IDLE || state_q == ST_POLL)) begin
      state_n = ST_RCTL;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      nxt_q   <= '0;
      buf_q   <= '0;
      rem_q   <= '0;
      ctl_q   <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cur_q   <= cur_n;
      nxt_q   <= nxt_n;
      buf_q   <= buf_n;
      rem_q   <= rem_n;
      ctl_q   <= ctl_n;
      first_q <= first_n;
      err_q   <= err_n;
      irq_q   <= irq_n;
    end
  end

  assign tx_data   = lane_byte;
  assign tx_sop    = tx_valid && first_q && ctl_q.sof;
  assign tx_eop    = tx_valid && (rem_q == CNT_W'(1)) && ctl_q.eof;
  assign chan_busy = (state_q != ST_IDLE);
  assign chan_held = (state_q == ST_POLL);
  assign chan_err  = err_q;
  assign irq_flag  = irq_q;

endmodule

// File: rtl/txdma_ring_chan_chk.sv
module txdma_ring_chan_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [31:0]       cfg_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-3:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_sop,
  input logic              tx_eop,
  input logic              chan_busy,
  input logic              chan_held,
  input logic              chan_err
);

  logic cmd_wr;
  logic unused_chk;

  assign cmd_wr     = cfg_we && (cfg_sel == 2'd1);
  assign unused_chk = ^{mem_addr, cfg_wdata[31:2]};

  assert_stream_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !cmd_wr) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

  assert_marker_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> (!tx_sop && !tx_eop));

  assert_writeback_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata == 32'h8000_0000 && mem_addr[1:0] == 2'b11));

  assert_held_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chan_held |-> (!tx_valid && !mem_we));

  assert_err_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_err |-> (!chan_busy && !mem_req));

  assert_off_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cfg_wdata[1:0] == 2'd0) |=> !chan_busy);

endmodule

bind txdma_ring_chan txdma_ring_chan_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/txdma_ring_chan_test.sv
`timescale 1ns/1ps
module txdma_ring_chan_test;

  localparam int ADDR_W = 16;
  localparam logic [31:0] HOLD = 32'h8000_0000;
  localparam logic [31:0] EOF  = 32'h4000_0000;
  localparam logic [31:0] SOF  = 32'h2000_0000;
  localparam logic [31:0] CPLI = 32'h1000_0000;
  localparam logic [31:0] EOFI = 32'h0800_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              cfg_we;
  logic [1:0]        cfg_sel;
  logic [31:0]       cfg_wdata;
  logic              mem_req, mem_we;
  logic [ADDR_W-3:0] mem_addr;
  logic [31:0]       mem_wdata, mem_rdata;
  logic              tx_valid, tx_ready;
  logic [7:0]        tx_data;
  logic              tx_sop, tx_eop;
  logic              chan_busy, chan_held, chan_err, irq_flag;

  txdma_ring_chan #(.ADDR_W(ADDR_W), .POLL_W(8)) uut (.*);

  logic [31:0] mem [0:1023];
  always @(posedge clk)
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:0]];
    end

  int n_tests = 0, n_fail = 0, cyc = 0, req_cnt = 0, watch_w = 8;
  bit ready_all = 1'b0;
  logic [7:0] rxq [$];
  bit rxs [$], rxe [$];
  int ptimes [$];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    tx_ready = ready_all ? 1'b1 : (($urandom % 4) != 0);
    if (tx_valid && tx_ready) begin
      rxq.push_back(tx_data); rxs.push_back(tx_sop); rxe.push_back(tx_eop);
    end
    if (mem_req) req_cnt++;
    if (mem_req && !mem_we && mem_addr[9:0] == watch_w[9:0]) ptimes.push_back(cyc);
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  task automatic cfg(logic [1:0] sel, logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic put_desc(int base, logic [31:0] ctl, int nxt, int bufa);
    mem[(base>>2)+0] = ctl; mem[(base>>2)+1] = nxt;
    mem[(base>>2)+2] = bufa; mem[(base>>2)+3] = 32'h0;
  endtask

  task automatic wait_done(int base, string req);
    int k = 0;
    while (!mem[(base>>2)+3][31] && k < 20000) begin @(negedge clk); k++; end
    chk(mem[(base>>2)+3] == 32'h8000_0000, req, "status word", mem[(base>>2)+3], 32'h8000_0000);
  endtask

  task automatic check_frame(int bufa, int len, bit s, bit e, string req);
    int bad = -1;
    logic [7:0] ab = 0, eb = 0;
    chk(rxq.size() >= len, req, "frame byte count", rxq.size(), len);
    for (int i = 0; i < len && rxq.size() > 0; i++) begin
      logic [7:0] b = rxq.pop_front();
      bit ps = rxs.pop_front(), pe = rxe.pop_front();
      if (bad < 0 && (b != mbyte(bufa + i) || ps != (s && i == 0) || pe != (e && i == len-1))) begin
        bad = i; ab = b; eb = mbyte(bufa + i);
      end
    end
    chk(bad < 0, req, "frame byte/marker mismatch at index", ab, eb);
  endtask

  task automatic fill(int lo, int hi);
    for (int a = lo; a < hi; a += 4) mem[a>>2] = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int l0, l1, l2;
    void'($urandom(32'd4711));
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 32'h0; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({chan_busy, chan_held, chan_err, irq_flag, tx_valid, mem_req} == 6'b0, "R1", "outputs in reset",
        {chan_busy, chan_held, chan_err, irq_flag, tx_valid, mem_req}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({chan_busy, tx_valid, mem_req} == 3'b0, "R1", "outputs after reset", {chan_busy, tx_valid, mem_req}, 0);

    // R2 R3 R4 R5 ring walk with unaligned buffer, stop at held slot
    fill(32'h100, 32'h400);
    l0 = 9; l1 = 1 + $urandom % 40;
    put_desc(32'h000, SOF | EOF | l0, 32'h010, 32'h103);
    put_desc(32'h010, SOF | EOF | CPLI | l1, 32'h020, 32'h200);
    put_desc(32'h020, HOLD | SOF | EOF | 4, 32'h000, 32'h300);
    cfg(2'd0, 32'h0);
    cfg(2'd1, 32'd1);
    wait_done(32'h010, "R5");
    repeat (10) @(negedge clk);
    chk(mem[3] == 32'h8000_0000, "R5", "first status", mem[3], 32'h8000_0000);
    check_frame(32'h103, l0, 1, 1, "R3");
    check_frame(32'h200, l1, 1, 1, "R4");
    chk(mem[(32'h020>>2)+3] == 0, "R6", "held status untouched", mem[(32'h020>>2)+3], 0);
    chk(chan_held == 1'b1, "R6", "held flag", chan_held, 1);
    chk(irq_flag == 1'b1, "R10", "completion flag", irq_flag, 1);

    // R6 polling interval, default 7 then 0 then 2
    watch_w = 32'h020 >> 2;
    ptimes.delete(); repeat (400) @(negedge clk);
    chk(ptimes.size() >= 2 && ptimes[$] - ptimes[$-1] == 115, "R6", "poll interval P=7",
        ptimes.size() >= 2 ? ptimes[$] - ptimes[$-1] : -1, 115);
    cfg(2'd2, 32'd0);
    repeat (150) @(negedge clk); ptimes.delete(); repeat (40) @(negedge clk);
    chk(ptimes.size() >= 2 && ptimes[$] - ptimes[$-1] == 3, "R6", "poll interval P=0",
        ptimes.size() >= 2 ? ptimes[$] - ptimes[$-1] : -1, 3);
    cfg(2'd2, 32'd2);
    repeat (60) @(negedge clk); ptimes.delete(); repeat (120) @(negedge clk);
    chk(ptimes.size() >= 2 && ptimes[$] - ptimes[$-1] == 35, "R6", "poll interval P=2",
        ptimes.size() >= 2 ? ptimes[$] - ptimes[$-1] : -1, 35);

    // R11 select 3 ignored
    cfg(2'd3, 32'hFFFF_FFFF);
    repeat (5) @(negedge clk);
    chk(chan_held && !chan_err && irq_flag, "R11", "select 3 write changed state",
        {chan_held, chan_err, irq_flag}, 3'b101);

    // R9 off, then work is ignored until resume; R7 zero length
    cfg(2'd1, 32'd0);
    chk(chan_busy == 1'b0, "R9", "busy after off", chan_busy, 0);
    chk(irq_flag == 1'b0, "R10", "flag cleared by command", irq_flag, 0);
    mem[32'h020>>2] = SOF | EOF;
    mem[0] = HOLD;
    l2 = req_cnt; rxq.delete();
    repeat (200) @(negedge clk);
    chk(req_cnt == l2 && mem[(32'h020>>2)+3] == 0 && rxq.size() == 0, "R9", "activity while off",
        req_cnt - l2, 0);
    cfg(2'd1, 32'd2);
    wait_done(32'h020, "R7");
    repeat (10) @(negedge clk);
    chk(rxq.size() == 0, "R7", "bytes for zero count", rxq.size(), 0);
    chk(chan_held == 1'b1, "R5", "ring wrapped to first slot held", chan_held, 1);

    // R9 resume cuts long poll; R8 misaligned next; R10 end-of-frame flag
    cfg(2'd2, 32'd255);
    repeat (20) @(negedge clk);
    l0 = 5 + $urandom % 26;
    put_desc(32'h000, SOF | EOF | EOFI | l0, 32'h013, 32'h300);
    ready_all = 1'b1;
    cfg(2'd1, 32'd2);
    repeat (12) @(negedge clk);
    chk(rxq.size() > 0, "R9", "bytes soon after resume", rxq.size(), 1);
    wait_done(32'h000, "R9");
    @(negedge clk);
    check_frame(32'h300, l0, 1, 1, "R3");
    chk(irq_flag == 1'b1, "R10", "end-of-frame flag", irq_flag, 1);
    chk(chan_err && !chan_busy, "R8", "misaligned next stops", {chan_err, chan_busy}, 2'b10);
    l2 = req_cnt; repeat (100) @(negedge clk);
    chk(req_cnt == l2, "R8", "memory access after error", req_cnt - l2, 0);
    ready_all = 1'b0;

    // random frames: R2 R3 R4 R7 R10
    cfg(2'd2, 32'd0);
    for (int it = 0; it < 8; it++) begin
      logic [31:0] ca, cb;
      int la = $urandom % 25, lb = $urandom % 25;
      int ba = 32'h100 + $urandom % 16, bb = 32'h180 + $urandom % 16;
      bit exp_irq;
      fill(32'h100, 32'h200);
      ca = ($urandom & (SOF | EOF | CPLI | EOFI)) | la;
      cb = ($urandom & (SOF | EOF | CPLI | EOFI)) | lb;
      put_desc(32'h040, ca, 32'h050, ba);
      put_desc(32'h050, cb, 32'h060, bb);
      put_desc(32'h060, HOLD, 32'h040, 32'h100);
      exp_irq = ca[28] | (ca[27] & ca[30]) | cb[28] | (cb[27] & cb[30]);
      rxq.delete(); rxs.delete(); rxe.delete();
      cfg(2'd0, 32'h040);
      cfg(2'd1, 32'd1);
      wait_done(32'h050, "R5");
      repeat (3) @(negedge clk);
      chk(mem[(32'h040>>2)+3] == 32'h8000_0000, "R5", "random first status", mem[(32'h040>>2)+3], 32'h8000_0000);
      check_frame(ba, la, ca[29], ca[30], "R4");
      check_frame(bb, lb, cb[29], cb[30], "R3");
      chk(rxq.size() == 0, "R7", "extra bytes", rxq.size(), 0);
      chk(irq_flag == exp_irq, "R10", "random flag", irq_flag, exp_irq);
    end

    // R8 misaligned first address
    cfg(2'd0, 32'h048);
    cfg(2'd1, 32'd1);
    chk(chan_err && !chan_busy, "R8", "misaligned first address", {chan_err, chan_busy}, 2'b10);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule